// File: doc/BRIEF.md
# Shared Memory Dependence Detector

This block watches a stream of memory references issued by several hardware threads and finds the points where one thread must wait for another if the run is to be replayed faithfully. Each reference carries a thread number, a load/store flag and an address. The address is folded into a small directory. Each directory slot stands for a range of addresses and holds two things: the thread that stored to it last, and one timestamp per thread giving that thread's most recent access.

When a reference hits a slot that another thread has touched in a conflicting way, the block emits ordering records. Each record states that the issuing thread may not perform its reference number n until the source thread has performed its reference number m. The conflict is classed as read-after-write, write-after-write or write-after-read. The slot is updated in the same cycle as the lookup, so the very next reference already sees the change.

Records leave over a valid/ready output channel. While a reference's records are still draining, the input channel is held not-ready.

Top module: `smdep_detector`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. Every slot has no last writer and all timestamps at 0, so the first reference to any slot emits no record.
- R2: The slot index is the XOR of the address bits above bit OFS_W-1, taken in IDX_W-bit chunks from bit OFS_W upward, with the top chunk zero-padded. With the defaults this is address bits [15:4] folded in 3-bit chunks. Addresses that share a slot index behave as one location.
- R3: Each thread keeps a reference count, starting at 0 after reset. An accepted reference gets the count plus one as its number n, and that value becomes the thread's new count.
- R4: A load whose slot has a last writer w different from the issuing thread emits one record with `out_kind`=1 (read-after-write), source w, and source count equal to w's timestamp in the slot.
- R5: A store whose slot has a last writer w different from the issuing thread emits a record with `out_kind`=2 (write-after-write), source w, and w's slot timestamp.
- R6: A store by a thread that is not the slot's last writer emits, for every other thread j that is not the last writer and has a nonzero slot timestamp, a record with `out_kind`=3 (write-after-read), source j, and j's slot timestamp.
- R7: No record is emitted on a load to a slot with no last writer or whose last writer is the issuing thread, nor on a store by the slot's last writer. No record ever names the same thread as both waiter and source.
- R8: An accepted load writes only the issuing thread's timestamp in the slot. An accepted store writes that timestamp and sets the last writer to the issuing thread.
- R9: All records from one reference carry the same waiting thread and count. They leave in ascending source-thread order, one per accepted output transfer, and `in_ready` stays 0 from the acceptance until the last of them has been taken.
- R10: A reference accepted in the cycle right after another reference to the same slot is classified against the slot as updated by that earlier reference.
- R11: While `out_valid` is 1 and `out_ready` is 0, every output field is held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A memory reference is offered |
| in_ready | output | 1 | The block can take a reference |
| in_tid | input | TID_W (2) | Issuing thread |
| in_store | input | 1 | 1 for a store, 0 for a load |
| in_addr | input | ADDR_W (16) | Effective address |
| out_valid | output | 1 | An ordering record is presented |
| out_ready | input | 1 | Consumer takes the record |
| out_kind | output | 2 | 1 read-after-write, 2 write-after-write, 3 write-after-read |
| out_wait_tid | output | TID_W (2) | Thread that must wait |
| out_wait_cnt | output | TS_W (16) | Waiting thread's reference number |
| out_src_tid | output | TID_W (2) | Thread that must go first |
| out_src_cnt | output | TS_W (16) | Source thread's reference number |

## Verification
Directed sequences cover the separate cases. A cross-thread load after a store must give a single read-after-write record. A store into a slot read by two threads and written by a third must give one write-after-write record plus write-after-read records in source order. Same-thread reuse must stay silent, which separates "other thread" checks from plain slot hits. Two addresses in one range, and two ranges that fold to one index, show that the hash decides aliasing, while a neighbouring range shows slots stay apart. Back-to-back references test that updates are visible at once. A long random mix of four threads over sixteen ranges aliased onto eight slots, with a stalling consumer, compares every record against a bench model and checks that held records do not move.

// File: rtl/smdep_pkg.sv
package smdep_pkg;
    typedef enum logic [1:0] {
        DEP_NONE = 2'd0,
        DEP_RAW  = 2'd1,
        DEP_WAW  = 2'd2,
        DEP_WAR  = 2'd3
    } dep_kind_e;
endpackage

// File: rtl/smdep_hash.sv
module smdep_hash #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 4,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int HI_W  = ADDR_W - OFS_W;
    localparam int NCH   = (HI_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W = NCH * IDX_W;

    logic [PAD_W-1:0] padded;
    logic [IDX_W-1:0] fold;

    always_comb begin
        padded = PAD_W'(addr[ADDR_W-1:OFS_W]);
        fold   = '0;
        for (int c = 0; c < NCH; c++) begin
            fold = fold ^ padded[c*IDX_W +: IDX_W];
        end
        idx = fold;
    end
endmodule

// File: rtl/smdep_directory.sv
module smdep_directory #(
    parameter int NTHR  = 4,
    parameter int IDX_W = 3,
    parameter int TS_W  = 16,
    parameter int TID_W = 2,
    parameter int LW_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [LW_W-1:0]            rd_lw,
    output logic [NTHR-1:0][TS_W-1:0]  rd_ts,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [TID_W-1:0]           wr_tid,
    input  logic                       wr_store,
    input  logic [TS_W-1:0]            wr_ts
);
    localparam int NENT = 1 << IDX_W;
    localparam logic [LW_W-1:0] NO_WRITER = LW_W'(NTHR);

    typedef struct packed {
        logic [LW_W-1:0]           lw;
        logic [NTHR-1:0][TS_W-1:0] ts;
    } slot_t;

    slot_t [NENT-1:0] tab_d, tab_q;

    assign rd_lw = tab_q[rd_idx].lw;
    assign rd_ts = tab_q[rd_idx].ts;

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            tab_d[wr_idx].ts[wr_tid] = wr_ts;
            if (wr_store) begin
                tab_d[wr_idx].lw = LW_W'(wr_tid);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NENT; e++) begin
                tab_q[e].lw <= NO_WRITER;
                tab_q[e].ts <= '0;
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    // R8
    store_sets_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_store |=> tab_q[$past(wr_idx)].lw == LW_W'($past(wr_tid)));

    // R8
    load_keeps_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_store |=> tab_q[$past(wr_idx)].lw == $past(tab_q[wr_idx].lw));

    // R8
    own_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tab_q[$past(wr_idx)].ts[$past(wr_tid)] == $past(wr_ts));
endmodule

// File: rtl/smdep_classify.sv
module smdep_classify
    import smdep_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int TS_W  = 16,
    parameter int TID_W = 2,
    parameter int LW_W  = 3
) (
    input  logic [TID_W-1:0]          tid,
    input  logic                      store,
    input  logic [LW_W-1:0]           lw,
    input  logic [NTHR-1:0][TS_W-1:0] ts,
    output logic [NTHR-1:0]           hit,
    output logic [NTHR-1:0][1:0]      kind
);
    logic self_is_writer;
    assign self_is_writer = (lw == LW_W'(tid));

    for (genvar j = 0; j < NTHR; j++) begin : g_src
        logic other, is_writer, touched;
        assign other     = (TID_W'(j) != tid);
        assign is_writer = (lw == LW_W'(j));
        assign touched   = (ts[j] != '0);

        always_comb begin
            hit[j]  = 1'b0;
            kind[j] = DEP_NONE;
            if (other) begin
                if (!store) begin
                    if (is_writer) begin
                        hit[j]  = 1'b1;
                        kind[j] = DEP_RAW;
                    end
                end else if (is_writer) begin
                    hit[j]  = 1'b1;
                    kind[j] = DEP_WAW;
                end else if (touched && !self_is_writer) begin
                    hit[j]  = 1'b1;
                    kind[j] = DEP_WAR;
                end
            end
        end
    end
endmodule

// File: rtl/smdep_emitter.sv
module smdep_emitter #(
    parameter int NTHR  = 4,
    parameter int TS_W  = 16,
    parameter int TID_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [NTHR-1:0]           hit,
    input  logic [NTHR-1:0][1:0]      kind,
    input  logic [NTHR-1:0][TS_W-1:0] ts,
    input  logic [TID_W-1:0]          wait_tid,
    input  logic [TS_W-1:0]           wait_cnt,
    output logic                      busy,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [1:0]                out_kind,
    output logic [TID_W-1:0]          out_wait_tid,
    output logic [TS_W-1:0]           out_wait_cnt,
    output logic [TID_W-1:0]          out_src_tid,
    output logic [TS_W-1:0]           out_src_cnt
);
    typedef struct packed {
        logic [NTHR-1:0]           pend;
        logic [NTHR-1:0][1:0]      kind;
        logic [NTHR-1:0][TS_W-1:0] ts;
        logic [TID_W-1:0]          wtid;
        logic [TS_W-1:0]           wcnt;
    } emit_t;

    emit_t           st_d, st_q;
    logic [NTHR-1:0] grant;
    logic [TID_W-1:0] sel;
    logic            found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        sel   = '0;
        for (int j = 0; j < NTHR; j++) begin
            if (st_q.pend[j] && !found) begin
                grant[j] = 1'b1;
                found    = 1'b1;
                sel      = TID_W'(j);
            end
        end
    end

    assign busy         = |st_q.pend;
    assign out_valid    = |st_q.pend;
    assign out_kind     = st_q.kind[sel];
    assign out_src_tid  = sel;
    assign out_src_cnt  = st_q.ts[sel];
    assign out_wait_tid = st_q.wtid;
    assign out_wait_cnt = st_q.wcnt;

    always_comb begin
        st_d = st_q;
        if (out_valid && out_ready) begin
            st_d.pend = st_q.pend & ~grant;
        end
        if (load) begin
            st_d.pend = hit;
            st_d.kind = kind;
            st_d.ts   = ts;
            st_d.wtid = wait_tid;
            st_d.wcnt = wait_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R11
    hold_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_src_tid)
            && $stable(out_src_cnt) && $stable(out_wait_tid) && $stable(out_wait_cnt));

    // R9
    no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);
endmodule

// File: rtl/smdep_detector.sv
module smdep_detector #(
    parameter int NTHR   = 4,
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 4,
    parameter int IDX_W  = 3,
    parameter int TS_W   = 16,
    localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TID_W-1:0]  in_tid,
    input  logic              in_store,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic [TID_W-1:0]  out_wait_tid,
    output logic [TS_W-1:0]   out_wait_cnt,
    output logic [TID_W-1:0]  out_src_tid,
    output logic [TS_W-1:0]   out_src_cnt
);
    localparam int LW_W = $clog2(NTHR + 1);

    logic [NTHR-1:0][TS_W-1:0] cnt_d, cnt_q;
    logic [IDX_W-1:0]          idx;
    logic [LW_W-1:0]           slot_lw;
    logic [NTHR-1:0][TS_W-1:0] slot_ts;
    logic [NTHR-1:0]           hit;
    logic [NTHR-1:0][1:0]      kind;
    logic                      accept, busy;
    logic [TS_W-1:0]           ref_num;

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;
    assign ref_num  = cnt_q[in_tid] + TS_W'(1);

    always_comb begin
        cnt_d = cnt_q;
        if (accept) begin
            cnt_d[in_tid] = ref_num;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    smdep_hash #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_hash (
        .addr (in_addr),
        .idx  (idx)
    );

    smdep_directory #(.NTHR(NTHR), .IDX_W(IDX_W), .TS_W(TS_W), .TID_W(TID_W), .LW_W(LW_W)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_lw    (slot_lw),
        .rd_ts    (slot_ts),
        .wr_en    (accept),
        .wr_idx   (idx),
        .wr_tid   (in_tid),
        .wr_store (in_store),
        .wr_ts    (ref_num)
    );

    smdep_classify #(.NTHR(NTHR), .TS_W(TS_W), .TID_W(TID_W), .LW_W(LW_W)) u_cls (
        .tid   (in_tid),
        .store (in_store),
        .lw    (slot_lw),
        .ts    (slot_ts),
        .hit   (hit),
        .kind  (kind)
    );

    smdep_emitter #(.NTHR(NTHR), .TS_W(TS_W), .TID_W(TID_W)) u_emit (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (accept),
        .hit          (hit),
        .kind         (kind),
        .ts           (slot_ts),
        .wait_tid     (in_tid),
        .wait_cnt     (ref_num),
        .busy         (busy),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_kind     (out_kind),
        .out_wait_tid (out_wait_tid),
        .out_wait_cnt (out_wait_cnt),
        .out_src_tid  (out_src_tid),
        .out_src_cnt  (out_src_cnt)
    );

    // R3
    ref_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> cnt_q[$past(in_tid)] == $past(cnt_q[in_tid]) + TS_W'(1));

    // R7
    distinct_threads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_src_tid != out_wait_tid);

    // R4
    kind_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_kind != 2'd0);
endmodule

// File: tb/smdep_detector_test.sv
module smdep_detector_test;
    localparam int NTHR = 4;
    localparam int NENT = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_store, out_ready;
    logic [1:0]  in_tid;
    logic [15:0] in_addr;
    logic        in_ready, out_valid;
    logic [1:0]  out_kind, out_wait_tid, out_src_tid;
    logic [15:0] out_wait_cnt, out_src_cnt;

    always #2.5 clk = ~clk;

    smdep_detector uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tid(in_tid), .in_store(in_store), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_wait_tid(out_wait_tid), .out_wait_cnt(out_wait_cnt),
        .out_src_tid(out_src_tid), .out_src_cnt(out_src_cnt)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // model state
    int m_lw [NENT];
    int m_ts [NENT][NTHR];
    int m_cnt [NTHR];
    // record packed as {kind, wait_tid, wait_cnt, src_tid, src_cnt}
    logic [37:0] expq [$];

    // held-record tracking for R11
    bit          held_prev = 0;
    logic [37:0] held_rec;

    function automatic int fold_idx(logic [15:0] a);
        logic [11:0] hi = a[15:4];
        return int'(hi[2:0] ^ hi[5:3] ^ hi[8:6] ^ hi[11:9]);
    endfunction

    function automatic string kind_req(logic [1:0] k);
        case (k)
            2'd1: return "R4";
            2'd2: return "R5";
            2'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int e = 0; e < NENT; e++) begin
            m_lw[e] = -1;
            for (int t = 0; t < NTHR; t++) m_ts[e][t] = 0;
        end
        for (int t = 0; t < NTHR; t++) m_cnt[t] = 0;
        expq.delete();
    endtask

    task automatic model_accept(int tid, bit st, logic [15:0] a);
        int e = fold_idx(a);
        int n = m_cnt[tid] + 1;
        bool_loop: for (int j = 0; j < NTHR; j++) begin
            logic [1:0] k = 2'd0;
            if (j == tid) continue;
            if (!st) begin
                if (m_lw[e] == j) k = 2'd1;
            end else if (m_lw[e] == j) begin
                k = 2'd2;
            end else if (m_ts[e][j] != 0 && m_lw[e] != tid) begin
                k = 2'd3;
            end
            if (k != 2'd0)
                expq.push_back({k, 2'(tid), 16'(n), 2'(j), 16'(m_ts[e][j])});
        end
        m_cnt[tid] = n;
        m_ts[e][tid] = n;
        if (st) m_lw[e] = tid;
    endtask

    // one cycle: drive at negedge, sample 1 ns later (before the rising edge)
    task automatic cycle(bit v, int tid, bit st, logic [15:0] a, bit ordy, output bit taken);
        logic [37:0] rec;
        @(negedge clk);
        in_valid = v; in_tid = 2'(tid); in_store = st; in_addr = a; out_ready = ordy;
        #1;
        taken = 0;
        rec = {out_kind, out_wait_tid, out_wait_cnt, out_src_tid, out_src_cnt};
        if (held_prev) begin
            check(out_valid && rec == held_rec, "R11", "held record moved", rec, held_rec);
        end
        held_prev = out_valid && !ordy;
        held_rec  = rec;
        if (out_valid) begin
            check(!in_ready, "R9", "in_ready while records pending", in_ready, 0);
        end
        if (out_valid && ordy) begin
            if (expq.size() == 0) begin
                check(0, "R7", "unexpected record", rec, 0);
            end else begin
                logic [37:0] e = expq.pop_front();
                check(rec == e, kind_req(e[37:36]), "record (R3 count, R9 order)", rec, e);
            end
        end
        if (v && in_ready) begin
            model_accept(tid, st, a);
            taken = 1;
        end
    endtask

    task automatic issue(int tid, bit st, logic [15:0] a, bit rnd_ready);
        bit taken = 0;
        while (!taken) cycle(1, tid, st, a, rnd_ready ? ($urandom % 10 < 7) : 1'b1, taken);
    endtask

    task automatic idle(int n);
        bit t;
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 16'h0, 1'b1, t);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n = 0; in_valid = 0; in_tid = 0; in_store = 0; in_addr = 0; out_ready = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R1
        check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
        check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);

        // R1: first touches emit nothing
        issue(0, 0, 16'h0100, 0);
        issue(1, 1, 16'h0200, 0);
        idle(3);
        check(expq.size() == 0 && !out_valid, "R1", "first access silent", out_valid, 0);

        // R4 RAW, R10 back-to-back (store then immediate foreign load, same range)
        issue(0, 1, 16'h0010, 0);
        issue(1, 0, 16'h001F, 0);
        idle(3);

        // R2: 0x0080 folds onto same slot as 0x0010; 0x0020 is a different slot
        issue(2, 0, 16'h0080, 0);
        idle(3);
        issue(3, 0, 16'h0020, 0);
        idle(2);
        check(!out_valid && expq.size() == 0, "R2", "separate slot silent", out_valid, 0);

        // R7: same-thread store and load on own slot
        issue(3, 1, 16'h0030, 0);
        issue(3, 0, 16'h0030, 0);
        issue(3, 1, 16'h0030, 0);
        idle(2);
        check(!out_valid, "R7", "own reuse silent", out_valid, 0);

        // R5 + R6 + R9: slot of 0x0050 read by T0,T1, written by T2, then T3 stores
        issue(0, 0, 16'h0050, 0);
        issue(1, 0, 16'h0050, 0);
        issue(2, 1, 16'h0050, 0);
        idle(3);
        issue(3, 1, 16'h0050, 0);
        idle(6);
        // R8: load by T0 must not change writer; T1 store then sees WAW against T3
        issue(0, 0, 16'h0050, 0);
        idle(3);
        issue(1, 1, 16'h0050, 0);
        idle(6);

        // random mix with stalling consumer
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a = {8'h00, 4'($urandom % 16), 4'($urandom % 16)};
            issue(int'($urandom % NTHR), bit'($urandom % 2), a, 1);
        end
        for (int i = 0; i < 40; i++) begin
            bit t;
            cycle(0, 0, 0, 16'h0, 1'b1, t);
        end
        check(expq.size() == 0 && !out_valid, "R9", "all records delivered", expq.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule